// File: doc/BRIEF.md
# Boot Partition Address Remapper

This block sits between a storage controller's command logic and a flat backing store whose first bytes hold two equally sized boot partitions, with the user area placed after both. Each host-side byte address, one per access port (port 0 carries block reads, port 1 carries block writes), is shifted by an offset. The offset depends on which partition the host has selected in the partition-configuration field. The address path is purely combinational, so the translated address is valid in the same cycle as the incoming one.

The block also computes the capacity the host may see. This is the raw store size minus the offset selected while reset is held. It is kept in a register that stops updating once reset is released. A selection code with no defined meaning raises an error flag and forces every translated address to zero, so no stray location can be reached.

Top module: `bootpart_remap`

## Requirements
- R1: When `mmcMode` is 0, every `physAddr` slice equals the matching `hostAddr` slice, and `accErr` is 0 whatever `partCfg` holds.
- R2: When the enable field `partCfg[5:3]` is zero, addresses pass through unchanged and `accErr` is 0 for every value of the access field `partCfg[2:0]`.
- R3: With the parameter `BOOT_BYTES` equal to zero, addresses pass through unchanged, `accErr` stays 0, and the capacity equals the raw size in every mode.
- R4: With `mmcMode` at 1, the enable field non-zero and access code 0 (user area), each port's output is its input plus twice `BOOT_BYTES`.
- R5: With the partition enabled and access code 1 (first boot partition), the offset is zero.
- R6: With the partition enabled and access code 2 (second boot partition), the offset is `BOOT_BYTES`.
- R7: With the partition enabled, `mmcMode` at 1 and `BOOT_BYTES` non-zero, access codes 3 to 7 set `accErr` to 1 and drive every `physAddr` slice to zero. In no other case is `accErr` set.
- R8: All ports use the same offset and are translated independently of one another.
- R9: The sum is taken modulo 2^`ADDR_W`, so addresses near the top of the range wrap around.
- R10: On every clock edge with `rst_n` low, `capacity` loads `rawSize` minus the current offset. With `rst_n` high, it holds its value when `rawSize`, `partCfg` or `mmcMode` change.
- R11: If `rawSize` is smaller than the offset at reset, `capacity` loads zero. An illegal access code at reset counts as a zero offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the capacity capture window |
| mmcMode | input | 1 | 1 selects managed-flash partition mapping |
| partCfg | input | 6 | Partition configuration: [5:3] enable, [2:0] access code |
| rawSize | input | ADDR_W | Total backing-store size in bytes |
| hostAddr | input | NUM_PORTS*ADDR_W | Host byte addresses, port p in bits [p*ADDR_W +: ADDR_W] |
| physAddr | output | NUM_PORTS*ADDR_W | Translated store addresses, same packing |
| accErr | output | 1 | Illegal access code selected |
| capacity | output | ADDR_W | Registered user-visible capacity |

## Verification
The bench builds two copies. The first uses a 32-bit address, two ports and a 128 KiB boot partition. Under this setting it runs through every access code, the enable and mode bypasses, wrap-around at the top of the address range, and a capacity that saturates when the raw size is smaller than the offset. The second uses a 16-bit address and a zero boot size, which shows that the zero-size bypass holds in every mode the first copy visits. A behavioural model in the bench predicts each output and is compared against it on every clock.

// File: rtl/bootpart_remap_pkg.sv
package bootpart_remap_pkg;

  // Field positions inside the partition-configuration input.
  localparam int unsigned ENA_LSB = 3;
  localparam int unsigned ENA_W   = 3;
  localparam int unsigned ACC_LSB = 0;
  localparam int unsigned ACC_W   = 3;
  localparam int unsigned CFG_W   = ENA_W + ACC_W;

  // Access codes with a defined meaning; everything above is illegal.
  typedef enum logic [ACC_W-1:0] {
    ACC_USER  = 3'd0,
    ACC_BOOT1 = 3'd1,
    ACC_BOOT2 = 3'd2
  } accCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic addOne;    // add one boot partition size
    logic addTwo;    // add two boot partition sizes
    logic blockOut;  // illegal selection: force outputs to zero
  } mapSel_t;

endpackage

// File: rtl/bootpart_remap_ctrl.sv
module bootpart_remap_ctrl
  import bootpart_remap_pkg::*;
#(
  parameter bit BOOT_ZERO = 1'b0
) (
  input  logic             mmcMode,
  input  logic [CFG_W-1:0] partCfg,
  output mapSel_t          sel
);

  logic [ENA_W-1:0] enaField;
  logic [ACC_W-1:0] accField;
  logic             bypass;

  assign enaField = partCfg[ENA_LSB +: ENA_W];
  assign accField = partCfg[ACC_LSB +: ACC_W];

  // Any of these conditions leaves the address untouched.
  assign bypass = !mmcMode || BOOT_ZERO || (enaField == '0);

  always_comb begin
    sel = '0;
    if (!bypass) begin
      case (accField)
        ACC_USER:  sel.addTwo   = 1'b1;
        ACC_BOOT1: sel          = '0;
        ACC_BOOT2: sel.addOne   = 1'b1;
        default:   sel.blockOut = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/bootpart_remap_dp.sv
module bootpart_remap_dp
  import bootpart_remap_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        NUM_PORTS  = 2,
  parameter logic [ADDR_W-1:0]  BOOT_BYTES = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mapSel_t                       sel,
  input  logic [ADDR_W-1:0]             rawSize,
  input  logic [NUM_PORTS*ADDR_W-1:0]   hostAddr,
  output logic [NUM_PORTS*ADDR_W-1:0]   physAddr,
  output logic [ADDR_W-1:0]             capacity
);

  localparam logic [ADDR_W-1:0] OFF_ONE = BOOT_BYTES;
  localparam logic [ADDR_W-1:0] OFF_TWO = {BOOT_BYTES[ADDR_W-2:0], 1'b0};

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] capNext;

  always_comb begin
    offset = '0;
    if (sel.addTwo)      offset = OFF_TWO;
    else if (sel.addOne) offset = OFF_ONE;
  end

  // One adder per port, all sharing the selected offset.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [ADDR_W-1:0] sum;
    assign sum = hostAddr[p*ADDR_W +: ADDR_W] + offset;
    assign physAddr[p*ADDR_W +: ADDR_W] = sel.blockOut ? '0 : sum;
  end

  // Capacity saturates at zero when the store is smaller than the offset.
  assign capNext = (rawSize >= offset) ? (rawSize - offset) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) capacity <= capNext;
  end

endmodule

// File: rtl/bootpart_remap.sv
module bootpart_remap
  import bootpart_remap_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        NUM_PORTS  = 2,
  parameter logic [ADDR_W-1:0]  BOOT_BYTES = 32'h0002_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mmcMode,
  input  logic [5:0]                    partCfg,
  input  logic [ADDR_W-1:0]             rawSize,
  input  logic [NUM_PORTS*ADDR_W-1:0]   hostAddr,
  output logic [NUM_PORTS*ADDR_W-1:0]   physAddr,
  output logic                          accErr,
  output logic [ADDR_W-1:0]             capacity
);

  localparam bit BOOT_ZERO = (BOOT_BYTES == '0);

  mapSel_t sel;

  bootpart_remap_ctrl #(.BOOT_ZERO(BOOT_ZERO)) u_ctrl (
    .mmcMode (mmcMode),
    .partCfg (partCfg),
    .sel     (sel)
  );

  bootpart_remap_dp #(
    .ADDR_W     (ADDR_W),
    .NUM_PORTS  (NUM_PORTS),
    .BOOT_BYTES (BOOT_BYTES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rawSize  (rawSize),
    .hostAddr (hostAddr),
    .physAddr (physAddr),
    .capacity (capacity)
  );

  assign accErr = sel.blockOut;

endmodule

// File: rtl/bootpart_remap_chk.sv
module bootpart_remap_chk #(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        NUM_PORTS  = 2,
  parameter logic [ADDR_W-1:0]  BOOT_BYTES = '0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          mmcMode,
  input logic [5:0]                    partCfg,
  input logic [NUM_PORTS*ADDR_W-1:0]   hostAddr,
  input logic [NUM_PORTS*ADDR_W-1:0]   physAddr,
  input logic                          accErr,
  input logic [ADDR_W-1:0]             capacity
);

  localparam logic [ADDR_W:0] TWICE = {BOOT_BYTES, 1'b0};
  localparam bit HAS_BOOT = (BOOT_BYTES != '0);

  AST_MODE_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !mmcMode |-> (physAddr == hostAddr) && !accErr); // R1

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (partCfg[5:3] == 3'd0) |-> (physAddr == hostAddr) && !accErr); // R2

  AST_USER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BOOT && mmcMode && partCfg[5:3] != 3'd0 && partCfg[2:0] == 3'd0)
    |-> physAddr[ADDR_W-1:0] == ADDR_W'(hostAddr[ADDR_W-1:0] + TWICE[ADDR_W-1:0])); // R4

  AST_BOOT2_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BOOT && mmcMode && partCfg[5:3] != 3'd0 && partCfg[2:0] == 3'd2)
    |-> physAddr[ADDR_W-1:0] == ADDR_W'(hostAddr[ADDR_W-1:0] + BOOT_BYTES)); // R6

  AST_ERR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    accErr |-> (physAddr == '0)); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    accErr |-> (HAS_BOOT && mmcMode && partCfg[5:3] != 3'd0 && partCfg[2:0] > 3'd2)); // R7

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BOOT && mmcMode && partCfg[5:3] != 3'd0 && partCfg[2:0] > 3'd2) |-> accErr); // R7

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(capacity)); // R10

endmodule

bind bootpart_remap bootpart_remap_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_PORTS  (NUM_PORTS),
  .BOOT_BYTES (BOOT_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mmcMode  (mmcMode),
  .partCfg  (partCfg),
  .hostAddr (hostAddr),
  .physAddr (physAddr),
  .accErr   (accErr),
  .capacity (capacity)
);

// File: tb/bootpart_remap_bench.sv
`timescale 1ns/1ps
module bootpart_remap_bench;

  localparam int WA = 32;
  localparam int WB = 16;
  localparam int NP = 2;
  localparam logic [WA-1:0] BOOTA = 32'h0002_0000;
  localparam logic [WB-1:0] BOOTB = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmcMode = 1'b1;
  logic [5:0] partCfg = 6'b001_000;
  logic [WA-1:0] rawA = 32'h0100_0000;
  logic [WB-1:0] rawB = 16'h8000;
  logic [NP*WA-1:0] hostA = '0;
  logic [NP*WB-1:0] hostB = '0;
  logic [NP*WA-1:0] physA;
  logic [NP*WB-1:0] physB;
  logic errA, errB;
  logic [WA-1:0] capA;
  logic [WB-1:0] capB;

  int tests = 0;
  int fails = 0;
  bit checkOn = 1'b0;
  bit done = 1'b0;
  string curTag = "R10";
  longint unsigned expCapA = 0;
  longint unsigned expCapB = 0;

  always #2.5 clk = ~clk;

  bootpart_remap #(.ADDR_W(WA), .NUM_PORTS(NP), .BOOT_BYTES(BOOTA)) u_bootpart_remap (
    .clk(clk), .rst_n(rst_n), .mmcMode(mmcMode), .partCfg(partCfg), .rawSize(rawA),
    .hostAddr(hostA), .physAddr(physA), .accErr(errA), .capacity(capA));

  bootpart_remap #(.ADDR_W(WB), .NUM_PORTS(NP), .BOOT_BYTES(BOOTB)) u_bootpart_remap_zero (
    .clk(clk), .rst_n(rst_n), .mmcMode(mmcMode), .partCfg(partCfg), .rawSize(rawB),
    .hostAddr(hostB), .physAddr(physB), .accErr(errB), .capacity(capB));

  // Reference offset from the requirement text.
  function automatic longint unsigned refOff(longint unsigned boot, bit mmc,
                                             logic [5:0] cfg, output bit err);
    err = 1'b0;
    if (!mmc || boot == 0 || cfg[5:3] == 3'd0) return 0;
    case (cfg[2:0])
      3'd0: return 2 * boot;
      3'd1: return 0;
      3'd2: return boot;
      default: begin err = 1'b1; return 0; end
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Capacity model: loads while reset is low, holds otherwise.
  always @(posedge clk) begin
    bit e;
    longint unsigned o;
    if (!rst_n) begin
      o = refOff(longint'(BOOTA), mmcMode, partCfg, e);
      expCapA = (longint'(rawA) >= o) ? longint'(rawA) - o : 0;
      o = refOff(longint'(BOOTB), mmcMode, partCfg, e);
      expCapB = (longint'(rawB) >= o) ? longint'(rawB) - o : 0;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    bit e;
    longint unsigned o;
    longint unsigned ex;
    if (checkOn) begin
      o = refOff(longint'(BOOTA), mmcMode, partCfg, e);
      for (int p = 0; p < NP; p++) begin
        ex = e ? 0 : ((longint'(hostA[p*WA +: WA]) + o) & 64'hFFFF_FFFF);
        chk(curTag, $sformatf("A port%0d addr", p), 64'(physA[p*WA +: WA]), ex);
      end
      chk(curTag, "A accErr", 64'(errA), 64'(e));
      chk(curTag, "A capacity", 64'(capA), expCapA);
      o = refOff(longint'(BOOTB), mmcMode, partCfg, e);
      for (int p = 0; p < NP; p++) begin
        ex = e ? 0 : ((longint'(hostB[p*WB +: WB]) + o) & 64'hFFFF);
        chk("R3", $sformatf("B port%0d addr", p), 64'(physB[p*WB +: WB]), ex);
      end
      chk("R3", "B accErr", 64'(errB), 64'(e));
      chk("R3", "B capacity", 64'(capB), expCapB);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setAddr(int i);
    hostA = {32'(i * 32'h0001_1000 + 32'h40), 32'(i * 32'h0003_0200 + 32'h1234)};
    hostB = {16'(i * 16'h0110 + 16'h4), 16'(i * 16'h0302 + 16'h12)};
  endtask

  task automatic sweep(string tag, logic [5:0] cfg, bit mmc);
    curTag = tag;
    partCfg = cfg;
    mmcMode = mmc;
    for (int i = 0; i < 5; i++) begin
      setAddr(i);
      step();
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R10: capacity captured during reset, user area enabled.
    step(); step();
    checkOn = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step();
    // R10: capacity holds after release when inputs move.
    rawA = 32'h0000_2000;
    rawB = 16'h0100;
    partCfg = 6'b010_010;
    step(); step();

    sweep("R1", 6'b001_000, 1'b0);
    sweep("R1", 6'b111_101, 1'b0);
    sweep("R2", 6'b000_000, 1'b1);
    sweep("R2", 6'b000_110, 1'b1);
    sweep("R4", 6'b001_000, 1'b1);
    sweep("R4", 6'b100_000, 1'b1);
    sweep("R5", 6'b001_001, 1'b1);
    sweep("R6", 6'b011_010, 1'b1);
    for (int a = 3; a < 8; a++) sweep("R7", {3'b001, 3'(a)}, 1'b1);

    // R8: very different addresses on the two ports.
    curTag = "R8";
    partCfg = 6'b001_010;
    hostA = {32'h0000_0000, 32'h7FFF_0000};
    hostB = {16'h0000, 16'hFFFF};
    step();
    hostA = {32'h1357_9BDF, 32'h0000_0001};
    step();

    // R9: wrap at the top of the address range.
    curTag = "R9";
    partCfg = 6'b001_000;
    hostA = {32'hFFFF_FFF0, 32'hFFFC_0000};
    hostB = {16'hFFF0, 16'hFFFF};
    step();
    partCfg = 6'b001_010;
    hostA = {32'hFFFE_0001, 32'hFFFF_FFFF};
    step();

    // R11: raw smaller than the offset saturates the capacity at zero.
    curTag = "R11";
    rst_n = 1'b0;
    rawA = 32'h0000_1000;
    partCfg = 6'b001_000;
    step(); step();
    rst_n = 1'b1;
    step();
    // R11: illegal code during reset counts as zero offset.
    rst_n = 1'b0;
    rawA = 32'h0004_5000;
    partCfg = 6'b001_110;
    step(); step();
    rst_n = 1'b1;
    step();
    partCfg = 6'b001_000;
    step();

    // R10: capture again with second boot partition selected.
    curTag = "R10";
    rst_n = 1'b0;
    rawA = 32'h0100_0000;
    partCfg = 6'b001_010;
    step(); step();
    rst_n = 1'b1;
    rawA = 32'h0000_0010;
    step(); step();

    checkOn = 1'b0;
    done = 1'b1;
    finishRun();
  end

endmodule